// File: doc/BRIEF.md
# Power-Good and Reset Status Generator

This block drives one active-high status line, intended for an open-drain pad, from the power-good comparator flags of two regulator channels. A two-bit select field picks which channels take part. A mode bit chooses between two behaviours. In power-good behaviour the line follows the monitored channels with no added delay. In reset behaviour the line is held low for a long, fixed interval after every monitored channel has become good.

Each channel's comparator flag goes through a filter that acts on falling edges only. A drop has to last a set number of microsecond ticks before it counts. After the final step of a dynamic output-voltage change, a channel's drops are ignored for a blanking window. A monitored channel that is switched off or in overcurrent pulls the line low at once, with no filtering. Timing is counted on a one-cycle `usTick` strobe from the system clock domain, so the interval parameters are expressed in microseconds.

Top module: `pg_reset_gen`

## Requirements
- R1: While `rstN` is low, `pgOut` is 0.
- R2: `monSel` selects the monitored channels, where bit 0 of `pgFlag`, `chanOn`, `overCur` and `stepDone` belongs to channel 0 and bit 1 to channel 1. The value 2'b00 monitors both channels, 2'b01 monitors channel 1 only and 2'b10 monitors channel 0 only. `pgOut` is 0 while any monitored channel is not good.
- R3: With `monSel` = 2'b11 no channel is monitored, and `pgOut` is 1 one clock later whatever the flags and the mode are.
- R4: With `rstMode` = 0, `pgOut` rises within two clocks once every monitored channel has its flag high, is on and is free of overcurrent.
- R5: With `rstMode` = 1, `pgOut` rises only after RESET_US ticks (default 125000, that is 125 ms) during which every monitored channel has stayed good.
- R6: If a monitored channel drops during the reset delay, the delay count restarts from zero once all monitored channels are good again.
- R7: A low `pgFlag` on a channel that is on and free of overcurrent clears that channel's good state only after GLITCH_US (default 32) consecutive ticks. A shorter low pulse has no effect on `pgOut`.
- R8: A one-cycle `stepDone` pulse on a channel starts a window of BLANK_US (default 192) ticks. During this window, low flags on that channel are ignored. A flag still low when the window ends is then filtered as in R7.
- R9: A monitored channel with `chanOn` low or `overCur` high drives `pgOut` to 0 within two clocks, without filtering and even inside a blanking window.
- R10: A change of `monSel` or `rstMode` takes effect on `pgOut` at the next clock edge.
- R11: Flags, off states and overcurrent on an unmonitored channel have no effect on `pgOut`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| usTick | input | 1 | One-cycle strobe once per microsecond |
| pgFlag | input | 2 | Per-channel comparator flag, 1 = output above its good threshold |
| chanOn | input | 2 | Per-channel enable state, 1 = channel running |
| overCur | input | 2 | Per-channel overcurrent indication, 1 = in overcurrent |
| stepDone | input | 2 | Per-channel pulse marking the last step of a voltage change |
| monSel | input | 2 | Channel monitoring select (see R2, R3) |
| rstMode | input | 1 | 0 = immediate power-good behaviour, 1 = delayed reset behaviour |
| pgOut | output | 1 | Status output, 1 = good (pad released) |

## Verification
A blanking window and a hard fault can arrive on the same channel in the same cycle. In that case the fault must win: the window only suppresses comparator drops, and must not hide an off or overcurrent channel. The bench provokes this by pulsing `stepDone` and dropping `chanOn` on one edge, and expects `pgOut` low two clocks later. The filter-expiry edge can also coincide with a new window. The checker covers that case by requiring that no channel's good state falls while its window is open and the channel is on and free of overcurrent.

// File: rtl/pgr_pkg.sv
package pgr_pkg;
  localparam int NCH = 2;

  typedef struct packed {
    logic [NCH-1:0] blankLoad;
    logic [NCH-1:0] lowClr;
    logic [NCH-1:0] lowInc;
    logic           delayClr;
  } pgrStrobeT;

  typedef struct packed {
    logic [NCH-1:0] blankActive;
    logic [NCH-1:0] lowExpired;
    logic           delayDone;
  } pgrStatusT;
endpackage

// File: rtl/pgr_datapath.sv
module pgr_datapath
  import pgr_pkg::*;
#(
  parameter int GLITCH_US = 32,
  parameter int BLANK_US  = 192,
  parameter int RESET_US  = 125000
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      usTick,
  input  pgrStrobeT stb,
  output pgrStatusT sts
);
  localparam int GW = $clog2(GLITCH_US + 1);
  localparam int BW = $clog2(BLANK_US + 1);
  localparam int DW = $clog2(RESET_US + 1);
  localparam logic [GW-1:0] GLITCH_MAX = GW'(GLITCH_US);
  localparam logic [BW-1:0] BLANK_MAX  = BW'(BLANK_US);
  localparam logic [DW-1:0] DELAY_MAX  = DW'(RESET_US);

  logic [NCH-1:0] blankAct;
  logic [NCH-1:0] lowExp;
  logic [DW-1:0]  delayCnt;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [BW-1:0] blankCnt;
    logic [GW-1:0] lowCnt;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        blankCnt <= '0;
      end else if (stb.blankLoad[c]) begin
        blankCnt <= BLANK_MAX;
      end else if (usTick && blankCnt != '0) begin
        blankCnt <= blankCnt - 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN || stb.lowClr[c]) begin
        lowCnt <= '0;
      end else if (stb.lowInc[c] && lowCnt != GLITCH_MAX) begin
        lowCnt <= lowCnt + 1'b1;
      end
    end

    assign blankAct[c] = (blankCnt != '0);
    assign lowExp[c]   = (lowCnt == GLITCH_MAX);
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.delayClr) begin
      delayCnt <= '0;
    end else if (usTick && delayCnt != DELAY_MAX) begin
      delayCnt <= delayCnt + 1'b1;
    end
  end

  always_comb begin
    sts.blankActive = blankAct;
    sts.lowExpired  = lowExp;
    sts.delayDone   = (delayCnt == DELAY_MAX);
  end
endmodule

// File: rtl/pgr_control.sv
module pgr_control
  import pgr_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           usTick,
  input  logic [NCH-1:0] pgFlag,
  input  logic [NCH-1:0] chanOn,
  input  logic [NCH-1:0] overCur,
  input  logic [NCH-1:0] stepDone,
  input  logic [1:0]     monSel,
  input  logic           rstMode,
  input  pgrStatusT      sts,
  output pgrStrobeT      stb,
  output logic [NCH-1:0] chGood,
  output logic           pgOut
);
  logic [NCH-1:0] monMask;
  logic [NCH-1:0] hardBad;
  logic [NCH-1:0] lowClr;
  logic           allGood;
  logic           outNext;

  // a set select bit removes its channel from monitoring
  assign monMask = ~monSel;
  assign hardBad = ~chanOn | overCur;
  assign lowClr  = pgFlag | hardBad | sts.blankActive;

  always_comb begin
    stb.blankLoad = stepDone;
    stb.lowClr    = lowClr;
    stb.lowInc    = {NCH{usTick}} & ~lowClr;
    stb.delayClr  = ~allGood;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_good
    always_ff @(posedge clk) begin
      if (!rstN) begin
        chGood[c] <= 1'b0;
      end else if (hardBad[c]) begin
        chGood[c] <= 1'b0;
      end else if (pgFlag[c]) begin
        chGood[c] <= 1'b1;
      end else if (sts.lowExpired[c] && !sts.blankActive[c]) begin
        chGood[c] <= 1'b0;
      end
    end
  end

  assign allGood = &(chGood | ~monMask);

  always_comb begin
    if (monMask == '0)      outNext = 1'b1;
    else if (!allGood)      outNext = 1'b0;
    else if (rstMode)       outNext = sts.delayDone;
    else                    outNext = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) pgOut <= 1'b0;
    else       pgOut <= outNext;
  end
endmodule

// File: rtl/pg_reset_gen.sv
module pg_reset_gen
  import pgr_pkg::*;
#(
  parameter int GLITCH_US = 32,
  parameter int BLANK_US  = 192,
  parameter int RESET_US  = 125000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       usTick,
  input  logic [1:0] pgFlag,
  input  logic [1:0] chanOn,
  input  logic [1:0] overCur,
  input  logic [1:0] stepDone,
  input  logic [1:0] monSel,
  input  logic       rstMode,
  output logic       pgOut
);
  pgrStrobeT      stb;
  pgrStatusT      sts;
  logic [NCH-1:0] chGood;

  pgr_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .usTick   (usTick),
    .pgFlag   (pgFlag),
    .chanOn   (chanOn),
    .overCur  (overCur),
    .stepDone (stepDone),
    .monSel   (monSel),
    .rstMode  (rstMode),
    .sts      (sts),
    .stb      (stb),
    .chGood   (chGood),
    .pgOut    (pgOut)
  );

  pgr_datapath #(
    .GLITCH_US (GLITCH_US),
    .BLANK_US  (BLANK_US),
    .RESET_US  (RESET_US)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .usTick (usTick),
    .stb    (stb),
    .sts    (sts)
  );
endmodule

// File: rtl/pgr_checker.sv
module pgr_checker
  import pgr_pkg::*;
(
  input logic           clk,
  input logic           rstN,
  input logic [NCH-1:0] pgFlag,
  input logic [NCH-1:0] chanOn,
  input logic [NCH-1:0] overCur,
  input logic [1:0]     monSel,
  input logic           rstMode,
  input logic           pgOut,
  input logic [NCH-1:0] chGood,
  input pgrStatusT      sts
);
  logic [1:0] sinceRst;
  logic       mon0Fault;
  logic       mon1Fault;
  logic       bothGood;

  always_ff @(posedge clk) begin
    if (!rstN)              sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 1'b1;
  end

  assign mon0Fault = !monSel[0] && (!chanOn[0] || overCur[0]);
  assign mon1Fault = !monSel[1] && (!chanOn[1] || overCur[1]);
  assign bothGood  = &(pgFlag & chanOn & ~overCur);

  // R1 and R3: an unmonitored select releases the line on the next edge
  p_hold_high_r3: assert property (@(posedge clk) disable iff (!rstN)
    (monSel == 2'b11) |=> pgOut);

  // R9: a monitored fault held over two samples forces the line low
  p_fault_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3 && $past(mon0Fault, 2) && $past(mon0Fault)) ||
    (sinceRst == 2'd3 && $past(mon1Fault, 2) && $past(mon1Fault)) |-> !pgOut);

  // R4: immediate rise in power-good behaviour
  p_pg_rise_r4: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3 && $past(bothGood, 2) && $past(bothGood) &&
     !$past(rstMode) && $past(monSel) == 2'b00) |-> pgOut);

  // R5: in reset behaviour a rise needs the elapsed delay
  p_reset_delay_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(pgOut) && $past(rstMode) && $past(monSel) != 2'b11) |-> $past(sts.delayDone));

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    // R7: a channel loses good state only by filter expiry or hard fault
    p_filter_r7: assert property (@(posedge clk) disable iff (!rstN)
      $fell(chGood[c]) |-> $past(sts.lowExpired[c] || !chanOn[c] || overCur[c]));

    // R8: no comparator-driven drop inside a blanking window
    p_blank_r8: assert property (@(posedge clk) disable iff (!rstN)
      (sts.blankActive[c] && chanOn[c] && !overCur[c]) |=> !$fell(chGood[c]));
  end
endmodule

bind pg_reset_gen pgr_checker u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .pgFlag  (pgFlag),
  .chanOn  (chanOn),
  .overCur (overCur),
  .monSel  (monSel),
  .rstMode (rstMode),
  .pgOut   (pgOut),
  .chGood  (chGood),
  .sts     (sts)
);

// File: tb/tb_pg_reset_gen.sv
module tb_pg_reset_gen;
  localparam int TICK_DIV  = 4;
  localparam int RESET_DLY = 50;
  localparam int WATCHDOG  = 100000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       usTick = 1'b0;
  logic [1:0] pgFlag = 2'b11;
  logic [1:0] chanOn = 2'b11;
  logic [1:0] overCur = 2'b00;
  logic [1:0] stepDone = 2'b00;
  logic [1:0] monSel = 2'b00;
  logic       rstMode = 1'b0;
  logic       pgOut;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  // {monSel, pgFlag, chanOn, overCur, expected}; rstMode = 0
  localparam int NVEC = 12;
  localparam logic [8:0] VEC [NVEC] = '{
    {2'b00, 2'b11, 2'b11, 2'b00, 1'b1},  // R2 both good
    {2'b00, 2'b10, 2'b11, 2'b00, 1'b0},  // R2 ch0 low
    {2'b00, 2'b01, 2'b11, 2'b00, 1'b0},  // R2 ch1 low
    {2'b01, 2'b10, 2'b11, 2'b00, 1'b1},  // R2 ch1 only, ch0 low ignored
    {2'b01, 2'b01, 2'b11, 2'b00, 1'b0},  // R2 ch1 only, ch1 low
    {2'b10, 2'b01, 2'b11, 2'b00, 1'b1},  // R2 ch0 only, ch1 low ignored
    {2'b10, 2'b10, 2'b11, 2'b00, 1'b0},  // R2 ch0 only, ch0 low
    {2'b11, 2'b00, 2'b00, 2'b11, 1'b1},  // R3 nothing monitored
    {2'b00, 2'b11, 2'b10, 2'b00, 1'b0},  // R9 ch0 off
    {2'b00, 2'b11, 2'b11, 2'b01, 1'b0},  // R9 ch0 overcurrent
    {2'b01, 2'b11, 2'b11, 2'b01, 1'b1},  // R11 unmonitored overcurrent
    {2'b10, 2'b11, 2'b01, 2'b00, 1'b1}   // R11 unmonitored off
  };

  pg_reset_gen #(.RESET_US(RESET_DLY)) dut (
    .clk      (clk),
    .rstN     (rstN),
    .usTick   (usTick),
    .pgFlag   (pgFlag),
    .chanOn   (chanOn),
    .overCur  (overCur),
    .stepDone (stepDone),
    .monSel   (monSel),
    .rstMode  (rstMode),
    .pgOut    (pgOut)
  );

  always #5 clk = ~clk;

  initial begin
    int div = 0;
    forever begin
      @(negedge clk);
      div = (div + 1) % TICK_DIV;
      usTick = (div == 0);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    cyc(n * TICK_DIV);
  endtask

  task automatic check(input logic exp, input string tag);
    checks++;
    if (pgOut !== exp) begin
      fails++;
      $display("FAIL %s: pgOut actual %b expected %b", tag, pgOut, exp);
    end
  endtask

  task automatic allGood();
    pgFlag = 2'b11; chanOn = 2'b11; overCur = 2'b00; stepDone = 2'b00;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run actual hung expected done");
    summary();
  end

  initial begin
    monSel = 2'b11;
    cyc(4);
    check(1'b0, "R1 reset holds low");
    rstN = 1'b1;
    monSel = 2'b00;
    cyc(3);

    // table walk, power-good behaviour
    for (int i = 0; i < NVEC; i++) begin
      allGood();
      monSel = 2'b00;
      cyc(3);
      monSel  = VEC[i][8:7];
      pgFlag  = VEC[i][6:5];
      chanOn  = VEC[i][4:3];
      overCur = VEC[i][2:1];
      ticks(40);
      check(VEC[i][0], $sformatf("R2/R3/R9/R11 vector %0d", i));
    end

    // R4 immediate rise
    allGood(); monSel = 2'b00; rstMode = 1'b0;
    chanOn[0] = 1'b0; cyc(3);
    check(1'b0, "R9 off drops line");
    chanOn[0] = 1'b1; cyc(2);
    check(1'b1, "R4 rise within two clocks");

    // R5 reset delay
    rstMode = 1'b1;
    chanOn[0] = 1'b0; cyc(3);
    chanOn[0] = 1'b1;
    ticks(RESET_DLY - 5);
    check(1'b0, "R5 still in delay");
    ticks(10);
    check(1'b1, "R5 released after delay");

    // R6 restart of the delay
    chanOn[0] = 1'b0; cyc(3);
    chanOn[0] = 1'b1;
    ticks(30);
    chanOn[1] = 1'b0; cyc(2);
    chanOn[1] = 1'b1;
    ticks(40);
    check(1'b0, "R6 delay restarted");
    ticks(20);
    check(1'b1, "R6 released after full delay");

    // R10 mode change
    chanOn[0] = 1'b0; cyc(3);
    chanOn[0] = 1'b1;
    ticks(5);
    check(1'b0, "R10 in reset delay");
    rstMode = 1'b0; cyc(1);
    check(1'b1, "R10 mode change next clock");

    // R10 select change
    monSel = 2'b10; chanOn[1] = 1'b0; cyc(3);
    check(1'b1, "R11 ch1 off ignored");
    monSel = 2'b00; cyc(1);
    check(1'b0, "R10 select change next clock");
    allGood(); cyc(3);

    // R3 in reset behaviour
    rstMode = 1'b1; monSel = 2'b11; chanOn = 2'b00; overCur = 2'b11; cyc(1);
    check(1'b1, "R3 unmonitored in reset mode");
    allGood(); rstMode = 1'b0; monSel = 2'b00; cyc(3);

    // R7 glitch filter
    pgFlag[0] = 1'b0; ticks(28);
    check(1'b1, "R7 short drop filtered");
    pgFlag[0] = 1'b1; cyc(2);
    pgFlag[0] = 1'b0; ticks(36);
    check(1'b0, "R7 long drop passes");
    allGood(); cyc(3);

    // R8 blanking after a voltage step
    stepDone[0] = 1'b1; cyc(1);
    stepDone[0] = 1'b0; pgFlag[0] = 1'b0;
    ticks(150);
    check(1'b1, "R8 drop blanked");
    ticks(60);
    check(1'b1, "R8 filter after window");
    ticks(30);
    check(1'b0, "R8 drop after window and filter");
    allGood(); ticks(200);

    // R9 hard fault in the same cycle as a window start
    stepDone[0] = 1'b1; chanOn[0] = 1'b0; cyc(1);
    stepDone[0] = 1'b0; cyc(1);
    check(1'b0, "R9 fault wins over blanking");
    allGood(); cyc(3);
    check(1'b1, "R4 recovery after fault");

    summary();
  end
endmodule